// File: doc/BRIEF.md
# Saturating Pipelined Signed Multiplier

This block is the multiply lane of a compute cluster. Each clock cycle it may accept one operation made of two 32-bit signed operands, a one-bit opcode and a destination tag. Four register stages later it returns a 32-bit result with the same tag. The first three stages capture the operands, build half-width partial products and sum them into the exact 64-bit signed product. The fourth stage limits that product to the 32-bit signed range and flags when limiting took place.

The surrounding controller issues work at up to one operation per cycle and matches results back to their destination through the tag. A no-operation opcode occupies the issue slot but never produces a result.

Top module: `mulsat_unit`

## Requirements
- R1: For a multiply whose exact product lies in [-2^31, 2^31-1], out_res equals the product and out_sat is 0.
- R2: A multiply accepted on rising edge N (in_vld=1, in_op=1) shows out_vld=1 right after rising edge N+3, so four rising edges capture it in total.
- R3: When the exact product is above 2^31-1, out_res is 0x7FFFFFFF and out_sat is 1.
- R4: When the exact product is below -2^31, out_res is 0x80000000 and out_sat is 1.
- R5: in_op encodes 0 as no-operation and 1 as multiply. A no-operation, or any cycle with in_vld=0, produces no out_vld pulse.
- R6: A new multiply can be accepted on every cycle, and results come out in issue order with one result per accepted multiply.
- R7: out_tag carries the in_tag presented with the operation that out_res belongs to.
- R8: While rst_n is low, and for the first cycles after it rises, out_vld is 0. Operations in flight when reset is asserted are dropped.
- R9: Products of exactly -2^31 or 2^31-1 are not limited: out_sat is 0. The product (-2^31)*(-2^31) is limited to 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| in_vld | input | 1 | Issue slot holds an operation |
| in_op | input | 1 | Opcode: 0 no-operation, 1 multiply |
| in_a | input | 32 | Signed multiplicand |
| in_b | input | 32 | Signed multiplier |
| in_tag | input | 4 | Destination tag carried with the operation |
| out_vld | output | 1 | Result present this cycle |
| out_res | output | 32 | Limited signed product |
| out_sat | output | 1 | Result was limited, qualified by out_vld |
| out_tag | output | 4 | Tag of the returning result |

## Verification
The cases that are hardest to reach from the ports are the exact edges of the signed range, because random operands almost never form a product of exactly -2^31, 2^31-1 or one step beyond them. The stimulus therefore builds these products on purpose from power-of-two factors, for example 65536*32768 and -65536*32768, and adds the full-scale negative square. A second hard case is a reset that arrives with work still in the pipe. The bench issues three multiplies, pulls reset before any of them can emerge, then watches that none of them appears after release.

// File: rtl/mulsat_pkg.sv
package mulsat_pkg;

  typedef enum logic {
    MS_OP_NOP = 1'b0,
    MS_OP_MUL = 1'b1
  } ms_op_e;

  localparam int unsigned MS_STAGES = 4;

endpackage

// File: rtl/mulsat_lane_ctl.sv
module mulsat_lane_ctl #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [DEPTH-1:0] vld_q,
  output logic [TAG_W-1:0] tag_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic             v_d;
    logic [TAG_W-1:0] t_d;
    logic             v_r;
    logic [TAG_W-1:0] t_r;

    if (i == 0) begin : g_head
      assign v_d = vld_i;
      assign t_d = tag_i;
    end else begin : g_tail
      assign v_d = g_stage[i-1].v_r;
      assign t_d = g_stage[i-1].t_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
      end else begin
        v_r <= v_d;
      end
    end

    always_ff @(posedge clk) begin
      if (v_d) begin
        t_r <= t_d;
      end
    end

    assign vld_q[i] = v_r;
  end

  assign tag_o = g_stage[DEPTH-1].t_r;

endmodule

// File: rtl/mulsat_pp.sv
module mulsat_pp #(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             en,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     pp_ll,
  output logic [W:0]       pp_lh,
  output logic [W:0]       pp_hl,
  output logic [W-1:0]     pp_hh
);

  localparam int unsigned H  = W / 2;
  localparam int unsigned CW = 2 * H + 1;

  logic [H-1:0]  a_lo, a_hi, b_lo, b_hi;
  logic [2*H-1:0] ll_d, hh_d;
  logic [2*H-1:0] ll_q, hh_q;

  assign a_lo = a[H-1:0];
  assign a_hi = a[W-1:H];
  assign b_lo = b[H-1:0];
  assign b_hi = b[W-1:H];

  assign ll_d = {{H{1'b0}}, a_lo} * {{H{1'b0}}, b_lo};
  assign hh_d = $signed({{H{a_hi[H-1]}}, a_hi}) * $signed({{H{b_hi[H-1]}}, b_hi});

  for (genvar k = 0; k < 2; k++) begin : g_cross
    logic [H-1:0]  lo_op;
    logic [H-1:0]  hi_op;
    logic [CW-1:0] x_d;
    logic [CW-1:0] x_q;

    if (k == 0) begin : g_alo_bhi
      assign lo_op = a_lo;
      assign hi_op = b_hi;
    end else begin : g_blo_ahi
      assign lo_op = b_lo;
      assign hi_op = a_hi;
    end

    assign x_d = $signed({{(H+1){1'b0}}, lo_op}) * $signed({{(H+1){hi_op[H-1]}}, hi_op});

    always_ff @(posedge clk) begin
      if (en) begin
        x_q <= x_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      ll_q <= ll_d;
      hh_q <= hh_d;
    end
  end

  assign pp_ll = ll_q;
  assign pp_hh = hh_q;
  assign pp_lh = g_cross[0].x_q;
  assign pp_hl = g_cross[1].x_q;

endmodule

// File: rtl/mulsat_acc.sv
module mulsat_acc #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           en,
  input  logic [W-1:0]   pp_ll,
  input  logic [W:0]     pp_lh,
  input  logic [W:0]     pp_hl,
  input  logic [W-1:0]   pp_hh,
  output logic [2*W-1:0] prod_q
);

  localparam int unsigned H  = W / 2;
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] ll_x, lh_x, hl_x, hh_x;
  logic [PW-1:0] sum_d;

  assign ll_x = {{W{1'b0}}, pp_ll};
  assign lh_x = {{(W-1){pp_lh[W]}}, pp_lh};
  assign hl_x = {{(W-1){pp_hl[W]}}, pp_hl};
  assign hh_x = {{W{pp_hh[W-1]}}, pp_hh};

  always_comb begin
    sum_d = ll_x + ((lh_x + hl_x) << H) + (hh_x << (2 * H));
  end

  always_ff @(posedge clk) begin
    if (en) begin
      prod_q <= sum_d;
    end
  end

endmodule

// File: rtl/mulsat_clamp.sv
module mulsat_clamp #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   res_q,
  output logic           sat_q
);

  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0]  RES_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  RES_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] LIM_HI  = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [PW-1:0] LIM_LO  = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  logic [W:0]   upper;
  logic         over, under;
  logic [W-1:0] res_d;
  logic         sat_d;

  assign upper = prod[PW-1:W-1];

  always_comb begin
    over  = ~prod[PW-1] & (|upper);
    under =  prod[PW-1] & ~(&upper);
    sat_d = over | under;
    if (over) begin
      res_d = RES_MAX;
    end else if (under) begin
      res_d = RES_MIN;
    end else begin
      res_d = prod[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      res_q <= res_d;
      sat_q <= sat_d;
    end
  end

  AST_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    en && ($signed(prod) > $signed(LIM_HI)) |=> sat_q && (res_q == RES_MAX)); // R3

  AST_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    en && ($signed(prod) < $signed(LIM_LO)) |=> sat_q && (res_q == RES_MIN)); // R4

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en && ($signed(prod) <= $signed(LIM_HI)) && ($signed(prod) >= $signed(LIM_LO))
    |=> !sat_q && (res_q == $past(prod[W-1:0]))); // R1

endmodule

// File: rtl/mulsat_unit.sv
module mulsat_unit
  import mulsat_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_vld,
  output logic [W-1:0]     out_res,
  output logic             out_sat,
  output logic [TAG_W-1:0] out_tag
);

  localparam int unsigned PW = 2 * W;

  logic                 rst_meta, rst_int;
  logic                 accept;
  logic [MS_STAGES-1:0] stg_vld;
  logic [W-1:0]         a_q, b_q;
  logic [W-1:0]         pp_ll, pp_hh;
  logic [W:0]           pp_lh, pp_hl;
  logic [PW-1:0]        prod;
  logic [W-1:0]         res_q;
  logic                 sat_q;
  logic [2:0]           age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  assign accept = in_vld && (ms_op_e'(in_op) == MS_OP_MUL);

  mulsat_lane_ctl #(.DEPTH(MS_STAGES), .TAG_W(TAG_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_int),
    .vld_i (accept),
    .tag_i (in_tag),
    .vld_q (stg_vld),
    .tag_o (out_tag)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      a_q <= in_a;
      b_q <= in_b;
    end
  end

  mulsat_pp #(.W(W)) u_pp (
    .clk   (clk),
    .en    (stg_vld[0]),
    .a     (a_q),
    .b     (b_q),
    .pp_ll (pp_ll),
    .pp_lh (pp_lh),
    .pp_hl (pp_hl),
    .pp_hh (pp_hh)
  );

  mulsat_acc #(.W(W)) u_acc (
    .clk    (clk),
    .en     (stg_vld[1]),
    .pp_ll  (pp_ll),
    .pp_lh  (pp_lh),
    .pp_hl  (pp_hl),
    .pp_hh  (pp_hh),
    .prod_q (prod)
  );

  mulsat_clamp #(.W(W)) u_clamp (
    .clk   (clk),
    .rst_n (rst_int),
    .en    (stg_vld[2]),
    .prod  (prod),
    .res_q (res_q),
    .sat_q (sat_q)
  );

  assign out_vld = stg_vld[MS_STAGES-1];
  assign out_res = res_q;
  assign out_sat = sat_q & stg_vld[MS_STAGES-1];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      age_q <= 3'd0;
    end else if (age_q != 3'd4) begin
      age_q <= age_q + 3'd1;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_int)
    (age_q == 3'd4) |-> (out_vld == $past(accept, 4))); // R2

  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int)
    (age_q == 3'd4) && out_vld |-> (out_tag == $past(in_tag, 4))); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_int)
    (age_q != 3'd4) |-> !out_vld); // R8

endmodule

// File: tb/mulsat_unit_test.sv
module mulsat_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic        in_op;
  logic [31:0] in_a, in_b;
  logic [3:0]  in_tag;
  logic        out_vld;
  logic [31:0] out_res;
  logic        out_sat;
  logic [3:0]  out_tag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seen   = 0;
  bit done   = 1'b0;

  logic [31:0] q_res[$];
  logic        q_sat[$];
  logic [3:0]  q_tag[$];
  int          q_cyc[$];
  string       q_req[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  mulsat_unit uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .out_vld(out_vld), .out_res(out_res), .out_sat(out_sat), .out_tag(out_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] r, output logic s);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    if (p > 64'sd2147483647) begin
      r = 32'h7FFF_FFFF; s = 1'b1;
    end else if (p < -64'sd2147483648) begin
      r = 32'h8000_0000; s = 1'b1;
    end else begin
      r = p[31:0]; s = 1'b0;
    end
  endfunction

  task automatic issue(input logic op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] tag, input string req);
    logic [31:0] r;
    logic        s;
    @(negedge clk);
    in_vld = 1'b1; in_op = op; in_a = a; in_b = b; in_tag = tag;
    if (op) begin
      model(a, b, r, s);
      q_res.push_back(r); q_sat.push_back(s); q_tag.push_back(tag);
      q_cyc.push_back(cyc); q_req.push_back(req);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0; in_op = 1'b0;
    end
  endtask

  task automatic flush();
    q_res.delete(); q_sat.delete(); q_tag.delete(); q_cyc.delete(); q_req.delete();
  endtask

  // monitor: pops the scoreboard whenever a result emerges
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_vld === 1'b1) begin
      seen++;
      if (q_res.size() == 0) begin
        chk(1'b0, "R5", "unexpected out_vld", 1, 0);
      end else begin
        logic [31:0] er; logic es; logic [3:0] et; int ec; string rq;
        er = q_res.pop_front(); es = q_sat.pop_front(); et = q_tag.pop_front();
        ec = q_cyc.pop_front(); rq = q_req.pop_front();
        chk(out_res == er, rq, "out_res", out_res, er);
        chk(out_sat == es, rq, "out_sat", out_sat, es);
        chk(out_tag == et, "R7", "out_tag", out_tag, et);
        chk((cyc - ec) == 4, "R2", "latency", cyc - ec, 4);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int seen0;
    logic [31:0] x;
    logic [3:0]  tg;
    rst_n = 1'b0; in_vld = 1'b0; in_op = 1'b0; in_a = '0; in_b = '0; in_tag = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_vld == 1'b0, "R8", "out_vld during reset", out_vld, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    chk(out_vld == 1'b0, "R8", "out_vld after release", out_vld, 0);

    // R1 in-range products
    issue(1'b1, 32'd3, 32'd4, 4'h1, "R1");
    issue(1'b1, -32'sd5, 32'd7, 4'h2, "R1");
    issue(1'b1, 32'd0, 32'hDEAD_BEEF, 4'h3, "R1");
    issue(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h4, "R1");
    issue(1'b1, 32'd12345, -32'sd678, 4'h5, "R1");
    // R3 overflow
    issue(1'b1, 32'h7FFF_FFFF, 32'd2, 4'h6, "R3");
    issue(1'b1, 32'd65536, 32'd32768, 4'h7, "R3");
    issue(1'b1, 32'h8000_0000, 32'h8000_0000, 4'h8, "R9");
    // R4 underflow
    issue(1'b1, 32'h8000_0000, 32'd2, 4'h9, "R4");
    issue(1'b1, -32'sd65536, 32'd32769, 4'hA, "R4");
    // R9 exact edges
    issue(1'b1, 32'h8000_0000, 32'd1, 4'hB, "R9");
    issue(1'b1, 32'h7FFF_FFFF, 32'd1, 4'hC, "R9");
    issue(1'b1, -32'sd65536, 32'd32768, 4'hD, "R9");
    idle(8);

    // R5 no-operation and idle slots produce nothing
    seen0 = seen;
    issue(1'b0, 32'd5, 32'd6, 4'h1, "R5");
    issue(1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'h2, "R5");
    idle(1);
    @(negedge clk); in_vld = 1'b0; in_op = 1'b1; in_a = 32'd9; in_b = 32'd9;
    issue(1'b0, 32'h8000_0000, 32'd3, 4'h3, "R5");
    idle(8);
    chk(seen == seen0, "R5", "results from no-op slots", seen - seen0, 0);

    // R6 back-to-back burst mixed with a no-op
    x = 32'h1234_5678; tg = 4'h0;
    for (int i = 0; i < 24; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      tg = tg + 4'h1;
      if (i == 11) issue(1'b0, x, x, tg, "R5");
      else if (i % 2 == 0) issue(1'b1, x, {{16{x[7]}}, x[23:8]}, tg, "R6");
      else issue(1'b1, x, {x[15:0], x[31:16]}, tg, "R6");
    end
    idle(8);
    chk(q_res.size() == 0, "R6", "results outstanding after burst", q_res.size(), 0);

    // R8 reset with work in flight
    issue(1'b1, 32'd100, 32'd200, 4'h5, "R8");
    issue(1'b1, 32'h7FFF_FFFF, 32'd9, 4'h6, "R8");
    issue(1'b1, -32'sd3, 32'd3, 4'h7, "R8");
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0; in_op = 1'b0;
    flush();
    seen0 = seen;
    @(negedge clk);
    chk(out_vld == 1'b0, "R8", "out_vld in mid-flight reset", out_vld, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(8);
    chk(seen == seen0, "R8", "dropped results reappeared", seen - seen0, 0);

    issue(1'b1, -32'sd7, -32'sd9, 4'hE, "R1");
    idle(8);
    chk(q_res.size() == 0, "R6", "results outstanding at end", q_res.size(), 0);
    report();
  end

endmodule